// File: doc/BRIEF.md
# Rotated Immediate Encoder and Expander

This block serves the short immediate field of a 32-bit RISC instruction word. The field is 12 bits: an unsigned 8-bit value and a 4-bit rotate count. To expand the field, the byte is zero-extended to a full word and then rotated right by twice the rotate count. Expansion is combinational. For an arbitrary 32-bit constant the block runs the reverse search, one candidate rotation per clock. It reports whether the constant fits the scheme and, if it does, the field that uses the smallest rotate count.

A third path merges 16-bit half-words into a register value. The low-half form places the half-word at the bottom and clears the top. The high-half form places the half-word at the top and keeps the bottom of the old value. The search sits behind a start/done handshake; the other two paths need no handshake. An asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `rotimm_unit`

## Requirements
- R1: `exp_operand_o` equals `exp_imm_i`, zero-extended to 32 bits, rotated right by 2*`exp_rot_i` bits. Examples: imm 121 with rot 12 gives 30976, and imm 230 with rot 6 gives 241172480.
- R2: With `exp_rot_i` = 0 the operand is the byte itself in bits 7:0, with bits 31:8 all zero.
- R3: When a search finds a match, `enc_valid_o` is 1. `enc_imm_o` and `enc_rot_o` then expand (per R1) to exactly the searched constant, and `enc_rot_o` is the smallest rotate count that does so.
- R4: Every constant from 0 to 255 encodes with `enc_rot_o` = 0 and `enc_imm_o` equal to the constant.
- R5: A constant with no encoding (for example 370, which would need an odd rotation) returns `enc_valid_o` = 0 with `enc_imm_o` and `enc_rot_o` both 0.
- R6: Count the rising edge that samples an accepted `enc_start_i` as edge 0. `enc_done_o` is then high for exactly one cycle, after edge r+1 when the result has rotate count r, and after edge 16 when there is no encoding. `enc_busy_o` is high from edge 0 until `enc_done_o` rises, and is low while `enc_done_o` is high.
- R7: `enc_start_i` is ignored while `enc_busy_o` is high. The running search keeps its constant and its timing.
- R8: With `hw_high_i` = 0, `hw_result_o` holds `hw_val_i` in bits 15:0 and zero in bits 31:16.
- R9: With `hw_high_i` = 1, `hw_result_o` holds `hw_val_i` in bits 31:16 and `hw_old_i[15:0]` in bits 15:0.
- R10: While reset is asserted, `enc_busy_o`, `enc_done_o` and `enc_valid_o` are 0, and `enc_imm_o` and `enc_rot_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exp_imm_i | input | 8 | Byte of the field to expand |
| exp_rot_i | input | 4 | Rotate count of the field to expand |
| exp_operand_o | output | 32 | Expanded operand |
| enc_start_i | input | 1 | Starts a search (honoured only when idle) |
| enc_const_i | input | 32 | Constant to search for, sampled with start |
| enc_busy_o | output | 1 | Search in progress |
| enc_done_o | output | 1 | One-cycle pulse: result is ready |
| enc_valid_o | output | 1 | Last constant searched has an encoding |
| enc_imm_o | output | 8 | Byte of the result field |
| enc_rot_o | output | 4 | Rotate count of the result field |
| hw_high_i | input | 1 | 1: write the upper half; 0: write the lower half |
| hw_val_i | input | 16 | Half-word to place |
| hw_old_i | input | 32 | Existing register value |
| hw_result_o | output | 32 | Merged register value |

## Verification
The assertions check the following on every cycle:
- the half-word merge rules and the rotate-zero expansion;
- that every valid result expands back to the constant captured at start;
- that the result fields are zero on a miss;
- that small constants use rotate zero;
- the single-cycle done pulse and the 16-cycle bound on busy.

Only the bench's scenarios can show the rest:
- that the chosen rotate is the smallest, which the bench checks against an independent brute-force search over every byte and rotation;
- that done arrives in the exact cycle R6 predicts;
- that a start issued mid-search leaves the result untouched.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;

  localparam int unsigned RIU_WORD_W = 32;
  localparam int unsigned RIU_IMM_W  = 8;
  localparam int unsigned RIU_ROT_W  = 4;
  localparam int unsigned RIU_HALF_W = 16;

  typedef enum logic {
    SRCH_IDLE,
    SRCH_SCAN
  } srch_state_e;

endpackage

// File: rtl/rotimm_expand.sv
module rotimm_expand #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic [WORD_W-1:0] operand_o
);

  localparam int unsigned AMT_W = ROT_W + 1;

  logic [AMT_W-1:0]    amt;
  logic [WORD_W-1:0]   ext;
  logic [2*WORD_W-1:0] twin;

  // Rotation amount is always even: twice the rotate count.
  assign amt  = {rot_i, 1'b0};
  assign ext  = {{(WORD_W-IMM_W){1'b0}}, imm_i};
  // Shifting a doubled copy right gives the rotate in its lower word.
  assign twin = {ext, ext} >> amt;
  assign operand_o = twin[WORD_W-1:0];

endmodule

// File: rtl/rotimm_search.sv
module rotimm_search
  import rotimm_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned ROT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] const_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [ROT_W-1:0]  rot_o
);

  localparam int unsigned AMT_W = ROT_W + 1;

  srch_state_e       state_q, state_d;
  logic [WORD_W-1:0] const_q;
  logic              const_en;
  logic [ROT_W-1:0]  rot_q, rot_d;
  logic              done_q, done_d;
  logic              res_en;
  logic              valid_q, valid_d;
  logic [IMM_W-1:0]  imm_q, imm_d;
  logic [ROT_W-1:0]  rres_q, rres_d;

  logic [AMT_W-1:0]    amt;
  logic [2*WORD_W-1:0] twin;
  logic [WORD_W-1:0]   undone;
  logic                hit;
  logic                last;

  // Undo the candidate rotation: rotate the constant left by 2*rot.
  assign amt    = {rot_q, 1'b0};
  assign twin   = {const_q, const_q} << amt;
  assign undone = twin[2*WORD_W-1:WORD_W];
  assign hit    = (undone[WORD_W-1:IMM_W] == '0);
  assign last   = (rot_q == {ROT_W{1'b1}});

  always_comb begin
    state_d  = state_q;
    rot_d    = rot_q;
    const_en = 1'b0;
    done_d   = 1'b0;
    res_en   = 1'b0;
    valid_d  = valid_q;
    imm_d    = imm_q;
    rres_d   = rres_q;
    unique case (state_q)
      SRCH_IDLE: begin
        if (start_i) begin
          state_d  = SRCH_SCAN;
          rot_d    = '0;
          const_en = 1'b1;
        end
      end
      SRCH_SCAN: begin
        if (hit) begin
          state_d = SRCH_IDLE;
          done_d  = 1'b1;
          res_en  = 1'b1;
          valid_d = 1'b1;
          imm_d   = undone[IMM_W-1:0];
          rres_d  = rot_q;
        end else if (last) begin
          state_d = SRCH_IDLE;
          done_d  = 1'b1;
          res_en  = 1'b1;
          valid_d = 1'b0;
          imm_d   = '0;
          rres_d  = '0;
        end else begin
          rot_d = rot_q + 1'b1;
        end
      end
      default: state_d = SRCH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRCH_IDLE;
      rot_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rot_q   <= rot_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      const_q <= '0;
    end else if (const_en) begin
      const_q <= const_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      imm_q   <= '0;
      rres_q  <= '0;
    end else if (res_en) begin
      valid_q <= valid_d;
      imm_q   <= imm_d;
      rres_q  <= rres_d;
    end
  end

  assign busy_o  = (state_q == SRCH_SCAN);
  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign imm_o   = imm_q;
  assign rot_o   = rres_q;

endmodule

// File: rtl/rotimm_halfmerge.sv
module rotimm_halfmerge #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic              high_i,
  input  logic [HALF_W-1:0] val_i,
  input  logic [WORD_W-1:0] old_i,
  output logic [WORD_W-1:0] result_o
);

  localparam int unsigned LOW_W = WORD_W - HALF_W;
  localparam logic [WORD_W-1:0] KEEP_MASK = {{HALF_W{1'b0}}, {LOW_W{1'b1}}};

  logic [WORD_W-1:0] low_form;
  logic [WORD_W-1:0] high_form;

  assign low_form  = {{(WORD_W-HALF_W){1'b0}}, val_i};
  assign high_form = {val_i, {LOW_W{1'b0}}} | (old_i & KEEP_MASK);
  assign result_o  = high_i ? high_form : low_form;

endmodule

// File: rtl/rotimm_unit.sv
module rotimm_unit
  import rotimm_pkg::*;
#(
  parameter int unsigned WORD_W = RIU_WORD_W,
  parameter int unsigned IMM_W  = RIU_IMM_W,
  parameter int unsigned ROT_W  = RIU_ROT_W,
  parameter int unsigned HALF_W = RIU_HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IMM_W-1:0]  exp_imm_i,
  input  logic [ROT_W-1:0]  exp_rot_i,
  output logic [WORD_W-1:0] exp_operand_o,
  input  logic              enc_start_i,
  input  logic [WORD_W-1:0] enc_const_i,
  output logic              enc_busy_o,
  output logic              enc_done_o,
  output logic              enc_valid_o,
  output logic [IMM_W-1:0]  enc_imm_o,
  output logic [ROT_W-1:0]  enc_rot_o,
  input  logic              hw_high_i,
  input  logic [HALF_W-1:0] hw_val_i,
  input  logic [WORD_W-1:0] hw_old_i,
  output logic [WORD_W-1:0] hw_result_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  // Assert at once, release after SYNC_STAGES clean edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  rotimm_expand #(
    .WORD_W (WORD_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
  ) u_expand (
    .imm_i     (exp_imm_i),
    .rot_i     (exp_rot_i),
    .operand_o (exp_operand_o)
  );

  rotimm_search #(
    .WORD_W (WORD_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
  ) u_search (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .start_i (enc_start_i),
    .const_i (enc_const_i),
    .busy_o  (enc_busy_o),
    .done_o  (enc_done_o),
    .valid_o (enc_valid_o),
    .imm_o   (enc_imm_o),
    .rot_o   (enc_rot_o)
  );

  rotimm_halfmerge #(
    .WORD_W (WORD_W),
    .HALF_W (HALF_W)
  ) u_merge (
    .high_i   (hw_high_i),
    .val_i    (hw_val_i),
    .old_i    (hw_old_i),
    .result_o (hw_result_o)
  );

endmodule

// File: rtl/rotimm_unit_chk.sv
module rotimm_unit_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned ROT_W  = 4,
  parameter int unsigned HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IMM_W-1:0]  exp_imm_i,
  input logic [ROT_W-1:0]  exp_rot_i,
  input logic [WORD_W-1:0] exp_operand_o,
  input logic              enc_start_i,
  input logic [WORD_W-1:0] enc_const_i,
  input logic              enc_busy_o,
  input logic              enc_done_o,
  input logic              enc_valid_o,
  input logic [IMM_W-1:0]  enc_imm_o,
  input logic [ROT_W-1:0]  enc_rot_o,
  input logic              hw_high_i,
  input logic [HALF_W-1:0] hw_val_i,
  input logic [WORD_W-1:0] hw_old_i,
  input logic [WORD_W-1:0] hw_result_o
);

  localparam int unsigned STEPS = 1 << ROT_W;
  localparam int unsigned LOW_W = WORD_W - HALF_W;
  localparam logic [WORD_W-1:0] LOW_MASK = {{HALF_W{1'b0}}, {LOW_W{1'b1}}};
  localparam logic [WORD_W-1:0] BYTE_LIM = WORD_W'(1) << IMM_W;

  logic [WORD_W-1:0]   cap_q;
  logic [ROT_W:0]      busy_cnt_q;
  logic [2*WORD_W-1:0] back_twin;
  logic [WORD_W-1:0]   back;

  // Expected constant: captured from the port whenever an idle start is seen.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else if (enc_start_i && !enc_busy_o) begin
      cap_q <= enc_const_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt_q <= '0;
    end else if (enc_busy_o) begin
      busy_cnt_q <= busy_cnt_q + 1'b1;
    end else begin
      busy_cnt_q <= '0;
    end
  end

  assign back_twin = {{(WORD_W-IMM_W){1'b0}}, enc_imm_o, {(WORD_W-IMM_W){1'b0}}, enc_imm_o}
                     >> {enc_rot_o, 1'b0};
  assign back      = back_twin[WORD_W-1:0];

  a_r2_rot_zero_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_rot_i == '0) |-> (exp_operand_o == {{(WORD_W-IMM_W){1'b0}}, exp_imm_i}));

  a_r3_roundtrip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_done_o && enc_valid_o) |-> (back == cap_q));

  a_r4_small_rot_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_done_o && (cap_q < BYTE_LIM)) |->
      (enc_valid_o && enc_rot_o == '0 && enc_imm_o == cap_q[IMM_W-1:0]));

  a_r5_miss_zeroed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_done_o && !enc_valid_o) |-> (enc_imm_o == '0 && enc_rot_o == '0));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_done_o |=> !enc_done_o);

  a_r6_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_done_o |-> !enc_busy_o);

  a_r6_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_busy_o |-> (busy_cnt_q < STEPS));

  a_r7_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enc_busy_o) |-> $past(enc_start_i));

  a_r8_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_high_i |-> (hw_result_o[WORD_W-1:LOW_W] == '0 &&
                    hw_result_o[HALF_W-1:0] == hw_val_i));

  a_r9_high_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_high_i |-> (hw_result_o[WORD_W-1:LOW_W] == hw_val_i &&
                   ((hw_result_o ^ hw_old_i) & LOW_MASK) == '0));

endmodule

bind rotimm_unit rotimm_unit_chk #(
  .WORD_W (WORD_W),
  .IMM_W  (IMM_W),
  .ROT_W  (ROT_W),
  .HALF_W (HALF_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_n_int),
  .exp_imm_i     (exp_imm_i),
  .exp_rot_i     (exp_rot_i),
  .exp_operand_o (exp_operand_o),
  .enc_start_i   (enc_start_i),
  .enc_const_i   (enc_const_i),
  .enc_busy_o    (enc_busy_o),
  .enc_done_o    (enc_done_o),
  .enc_valid_o   (enc_valid_o),
  .enc_imm_o     (enc_imm_o),
  .enc_rot_o     (enc_rot_o),
  .hw_high_i     (hw_high_i),
  .hw_val_i      (hw_val_i),
  .hw_old_i      (hw_old_i),
  .hw_result_o   (hw_result_o)
);

// File: tb/tb_rotimm_unit.sv
module tb_rotimm_unit;

  localparam int CLK_PERIOD  = 10;
  localparam int WDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  exp_imm;
  logic [3:0]  exp_rot;
  logic [31:0] exp_operand;
  logic        enc_start;
  logic [31:0] enc_const;
  logic        enc_busy, enc_done, enc_valid;
  logic [7:0]  enc_imm;
  logic [3:0]  enc_rot;
  logic        hw_high;
  logic [15:0] hw_val;
  logic [31:0] hw_old, hw_result;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotimm_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .exp_imm_i(exp_imm), .exp_rot_i(exp_rot), .exp_operand_o(exp_operand),
    .enc_start_i(enc_start), .enc_const_i(enc_const), .enc_busy_o(enc_busy),
    .enc_done_o(enc_done), .enc_valid_o(enc_valid), .enc_imm_o(enc_imm), .enc_rot_o(enc_rot),
    .hw_high_i(hw_high), .hw_val_i(hw_val), .hw_old_i(hw_old), .hw_result_o(hw_result)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One-bit-at-a-time rotate right, kept apart from any shifter form.
  function automatic logic [31:0] ror_n(input logic [31:0] x, input int n);
    logic [31:0] y = x;
    for (int i = 0; i < n; i++) y = {y[0], y[31:1]};
    return y;
  endfunction

  // Brute force: smallest rotate first, every byte tried.
  task automatic ref_encode(input logic [31:0] c, output bit ok, output logic [7:0] v, output logic [3:0] r);
    ok = 1'b0; v = '0; r = '0;
    for (int rr = 0; rr < 16 && !ok; rr++) begin
      for (int vv = 0; vv < 256 && !ok; vv++) begin
        if (ror_n(32'(vv), 2*rr) == c) begin
          ok = 1'b1; v = 8'(vv); r = 4'(rr);
        end
      end
    end
  endtask

  task automatic run_encode(input logic [31:0] c, input string tag, input bit poke_busy);
    bit          ok;
    logic [7:0]  ev;
    logic [3:0]  er;
    int          k;
    int          exp_k;
    ref_encode(c, ok, ev, er);
    exp_k = ok ? int'(er) + 2 : 17;
    @(negedge clk);
    enc_start = 1'b1;
    enc_const = c;
    @(negedge clk);
    enc_start = 1'b0;
    enc_const = 32'hDEAD_BEEF;
    k = 1;
    chk(enc_busy == 1'b1, {tag, " R6 busy after start"}, 32'(enc_busy), 32'd1);
    while (!enc_done && k < 40) begin
      if (poke_busy && k == 3) begin
        enc_start = 1'b1;
        enc_const = 32'h0000_0005;
      end
      @(negedge clk);
      enc_start = 1'b0;
      k++;
    end
    chk(k == exp_k, {tag, " R6 done cycle"}, 32'(k), 32'(exp_k));
    chk(enc_busy == 1'b0, {tag, " R6 idle at done"}, 32'(enc_busy), 32'd0);
    chk(enc_valid == ok, {tag, " R3/R5 valid"}, 32'(enc_valid), 32'(ok));
    chk(enc_imm == ev, {tag, " R3/R5 imm"}, 32'(enc_imm), 32'(ev));
    chk(enc_rot == er, {tag, " R3/R5 smallest rot"}, 32'(enc_rot), 32'(er));
    if (enc_valid) begin
      exp_imm = enc_imm;
      exp_rot = enc_rot;
      #1;
      chk(exp_operand == c, {tag, " R3 roundtrip via expand"}, exp_operand, c);
    end
    @(negedge clk);
    chk(enc_done == 1'b0, {tag, " R6 done one cycle"}, 32'(enc_done), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYCLES);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] c;
    seed = 32'h1357_9BDF;
    rst_n = 1'b0;
    enc_start = 1'b0; enc_const = '0;
    exp_imm = '0; exp_rot = '0;
    hw_high = 1'b0; hw_val = '0; hw_old = '0;
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    chk(enc_busy == 1'b0, "R10 busy", 32'(enc_busy), 0);
    chk(enc_done == 1'b0, "R10 done", 32'(enc_done), 0);
    chk(enc_valid == 1'b0, "R10 valid", 32'(enc_valid), 0);
    chk({enc_imm, enc_rot} == '0, "R10 fields", 32'({enc_imm, enc_rot}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 named vectors
    exp_imm = 8'd121; exp_rot = 4'd12; #1;
    chk(exp_operand == 32'd30976, "R1 121 rot 12", exp_operand, 32'd30976);
    exp_imm = 8'd230; exp_rot = 4'd6; #1;
    chk(exp_operand == 32'd241172480, "R1 230 rot 6", exp_operand, 32'd241172480);
    // R1 / R2 exhaustive expansion
    for (int r = 0; r < 16; r++) begin
      for (int v = 0; v < 256; v++) begin
        exp_imm = 8'(v); exp_rot = 4'(r); #1;
        if (r == 0)
          chk(exp_operand == 32'(v), "R2 rot zero", exp_operand, 32'(v));
        else
          chk(exp_operand == ror_n(32'(v), 2*r), "R1 sweep", exp_operand, ror_n(32'(v), 2*r));
      end
    end

    // R4: every byte-sized constant
    for (int v = 0; v < 256; v++) run_encode(32'(v), "R4 small", 1'b0);

    // R3: constants built from bytes at every rotation
    for (int r = 0; r < 16; r++) begin
      run_encode(ror_n(32'h01, 2*r), "R3 single bit", 1'b0);
      run_encode(ror_n(32'h81, 2*r), "R3 split byte", 1'b0);
      run_encode(ror_n(32'hFF, 2*r), "R3 full byte", 1'b0);
      run_encode(ror_n(32'hC0, 2*r), "R3 high pair", 1'b0);
      run_encode(ror_n(32'h5A, 2*r), "R3 mixed", 1'b0);
    end

    // R5: constants with no encoding
    run_encode(32'd370, "R5 370", 1'b0);
    run_encode(32'h0000_0101, "R5 wide", 1'b0);
    run_encode(32'h0000_01FE, "R5 odd shift", 1'b0);
    run_encode(32'hFFFF_FFFF, "R5 all ones", 1'b0);
    run_encode(32'h0000_FFFF, "R5 half word", 1'b0);

    // R7: start while busy must not disturb a full-length search
    run_encode(32'd370, "R7 ignored start", 1'b1);

    // R3 / R5 mixed pseudo-random constants
    for (int i = 0; i < 64; i++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      c = (i % 2 == 0) ? ror_n(seed & 32'hFF, 2 * int'(seed[31:28])) : seed;
      run_encode(c, "R3/R5 random", 1'b0);
    end

    // R8 / R9 half-word merge
    for (int i = 0; i < 48; i++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      hw_val = seed[15:0];
      hw_old = seed ^ 32'hA5A5_0F0F;
      hw_high = 1'b0; #1;
      chk(hw_result == {16'h0, hw_val}, "R8 low half", hw_result, {16'h0, hw_val});
      hw_high = 1'b1; #1;
      chk(hw_result == {hw_val, hw_old[15:0]}, "R9 high half", hw_result, {hw_val, hw_old[15:0]});
    end

    finish_run();
  end

endmodule